// File: doc/BRIEF.md
# Source-Route Detour Rewriter

This unit sits next to a mesh router as an extra internal port. When an input port holds a header flit whose hop list points at a prohibited output, it hands the header over, together with its own port number, the blocked output number and the virtual channel. The unit keeps the header in a single buffer shared by both virtual channels. It decides where the blocked neighbour sits relative to the path: in a straight run, just before the X-to-Y turn, or at the turn itself. It then edits the hop list so the packet steps around that neighbour. If the blocked router is the packet's destination, or the edit cannot be made, the packet is discarded.

The rewritten header leaves on the newly chosen output port. At the same time, a command goes back to the requesting input port, so that it steers the rest of the packet to that port or drops it. The body flits themselves never pass through this unit. If the chosen output is not free, the unit holds the header, tries again on every cycle, and refuses new requests until it can issue.

Top module: `rr_path_rewriter`

## Requirements
- R1: After reset, `busy_o`, `hdr_valid_o`, `cmd_valid_o` and `cmd_drop_o` are all low.
- R2: A request is captured only when `busy_o` is low. `busy_o` is high from the next cycle until the cycle after the command is issued. A request made while `busy_o` is high is ignored and changes no output.
- R3: Hops are 3-bit codes: 0 local, 1 north, 2 east, 3 south, 4 west. Hop k occupies bits [3k+2:3k] of the path, and hop 0 is the hop toward the blocked output. The length field counts the valid hops, up to HOPS.
- R4: Straight case. Hop 1 equals the blocked direction d, and hop 2 is absent or not perpendicular to d. The path becomes side s, d, d, the opposite of s, then old hops 2 onward. The length grows by 2 and the new port is s.
- R5: Before-turn case. Hop 1 is d and hop 2 is a perpendicular t. The path becomes t, d, d, then old hops 3 onward. The length is unchanged and the new port is t.
- R6: Corner case. Hop 1 is perpendicular to d. Hops 0 and 1 are exchanged, the length is unchanged, and the new port is the old hop 1.
- R7: Side selection in the straight case. For a vertical d, west is tried first and then east. For a horizontal d, north is tried first and then south. A side is legal only if its output is free and it is not the requesting input port.
- R8: The packet is dropped (`cmd_drop_o` high, no header issued) in these cases: the length is 1 or less, d is local or not a valid code, hop 1 is neither d nor perpendicular to d, or a straight case would exceed HOPS.
- R9: If the required new port is busy or equals the requesting input port, the unit issues nothing and re-evaluates on every cycle. It issues in the first cycle the port becomes legal.
- R10: The header and the command appear together in the cycle after capture when no wait is needed. The command carries the requesting input port and the virtual channel, and the header carries the same virtual channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Header hand-over request |
| req_vc_i | input | VC_W | Virtual channel of the header |
| req_inport_i | input | 3 | Requesting input port code |
| req_blk_i | input | 3 | Blocked output port code |
| req_path_i | input | HOPS*3 | Hop list of the header |
| req_len_i | input | LEN_W | Number of valid hops |
| out_free_i | input | 5 | One bit per output port, set when free |
| busy_o | output | 1 | Buffer occupied, requests refused |
| hdr_valid_o | output | 1 | Rewritten header offered |
| hdr_vc_o | output | VC_W | Virtual channel of the header |
| hdr_port_o | output | 3 | New output port |
| hdr_path_o | output | HOPS*3 | Rewritten hop list |
| hdr_len_o | output | LEN_W | Rewritten hop count |
| cmd_valid_o | output | 1 | Command to the requesting input port |
| cmd_inport_o | output | 3 | Input port addressed by the command |
| cmd_vc_o | output | VC_W | Virtual channel of the command |
| cmd_drop_o | output | 1 | Discard the packet instead of redirecting it |

## Verification
A request is captured at one rising edge. The header and the command are combinational from the buffer, so they are due in the cycle that follows, and the bench samples them at the next falling edge. When the unit is waiting, the bench samples again 1 ns after it changes `out_free_i`. The buffer empties at the following edge, so the bench checks at the next falling edge that `busy_o` is low and that a request refused during the wait left no trace.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int HOP_W = 3;
  localparam int PORTS = 5;
  localparam logic [2:0] DIR_L = 3'd0;
  localparam logic [2:0] DIR_N = 3'd1;
  localparam logic [2:0] DIR_E = 3'd2;
  localparam logic [2:0] DIR_S = 3'd3;
  localparam logic [2:0] DIR_W = 3'd4;

  function automatic logic is_mesh(input logic [2:0] d);
    return (d != DIR_L) && (d <= DIR_W);
  endfunction

  function automatic logic is_vert(input logic [2:0] d);
    return (d == DIR_N) || (d == DIR_S);
  endfunction

  function automatic logic is_perp(input logic [2:0] a, input logic [2:0] b);
    return is_mesh(a) && is_mesh(b) && (is_vert(a) != is_vert(b));
  endfunction

  function automatic logic [2:0] opp(input logic [2:0] d);
    case (d)
      DIR_N:   return DIR_S;
      DIR_S:   return DIR_N;
      DIR_E:   return DIR_W;
      DIR_W:   return DIR_E;
      default: return DIR_L;
    endcase
  endfunction
endpackage

// File: rtl/rr_side_pick.sv
module rr_side_pick
  import rr_pkg::*;
(
  input  logic [2:0]       blk_i,
  input  logic [2:0]       in_port_i,
  input  logic [PORTS-1:0] free_i,
  output logic             ok_o,
  output logic [2:0]       side_o
);
  logic [2:0] first, second;
  logic       first_ok, second_ok;

  // vertical blockage: west first; horizontal: north first
  assign first  = is_vert(blk_i) ? DIR_W : DIR_N;
  assign second = is_vert(blk_i) ? DIR_E : DIR_S;

  assign first_ok  = free_i[first]  && (first  != in_port_i);
  assign second_ok = free_i[second] && (second != in_port_i);

  assign ok_o   = first_ok || second_ok;
  assign side_o = first_ok ? first : second;
endmodule

// File: rtl/rr_path_edit.sv
module rr_path_edit
  import rr_pkg::*;
#(
  parameter int HOPS   = 16,
  parameter int LEN_W  = $clog2(HOPS + 1),
  parameter int PATH_W = HOPS * HOP_W
) (
  input  logic [PATH_W-1:0] path_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [2:0]        blk_i,
  input  logic [2:0]        in_port_i,
  input  logic [PORTS-1:0]  free_i,
  input  logic              side_ok_i,
  input  logic [2:0]        side_i,
  output logic              drop_o,
  output logic              ready_o,
  output logic [2:0]        port_o,
  output logic [PATH_W-1:0] path_o,
  output logic [LEN_W-1:0]  len_o
);
  logic [2:0] hop_q [HOPS];
  logic [2:0] hop_n [HOPS];

  for (genvar k = 0; k < HOPS; k++) begin : g_unpack
    assign hop_q[k] = path_i[k*HOP_W +: HOP_W];
    assign path_o[k*HOP_W +: HOP_W] = hop_n[k];
  end

  logic corner, before_turn, straight, room, port_ok;

  assign corner      = (len_i >= LEN_W'(2)) && is_perp(hop_q[1], blk_i);
  assign before_turn = (len_i >= LEN_W'(3)) && (hop_q[1] == blk_i) && is_perp(hop_q[2], blk_i);
  assign straight    = (len_i >= LEN_W'(2)) && (hop_q[1] == blk_i) && !before_turn;
  assign room        = len_i <= LEN_W'(HOPS - 2);

  assign drop_o = !is_mesh(blk_i) || (len_i <= LEN_W'(1)) ||
                  !(corner || before_turn || straight) || (straight && !room);

  always_comb begin
    port_o = side_i;
    if (corner)           port_o = hop_q[1];
    else if (before_turn) port_o = hop_q[2];
  end

  assign port_ok = straight ? side_ok_i : (free_i[port_o] && (port_o != in_port_i));
  assign ready_o = !drop_o && port_ok;
  assign len_o   = straight ? len_i + LEN_W'(2) : len_i;

  always_comb begin
    for (int k = 0; k < HOPS; k++) begin
      hop_n[k] = hop_q[k];
      if (corner) begin
        if (k == 0) hop_n[k] = hop_q[1];
        if (k == 1) hop_n[k] = blk_i;
      end else if (before_turn) begin
        if (k == 0)           hop_n[k] = hop_q[2];
        if (k == 1 || k == 2) hop_n[k] = blk_i;
      end else if (straight) begin
        if (k == 0)           hop_n[k] = side_i;
        else if (k <= 2)      hop_n[k] = blk_i;
        else if (k == 3)      hop_n[k] = opp(side_i);
        else                  hop_n[k] = hop_q[(k >= 2) ? k - 2 : 0];
      end
    end
  end
endmodule

// File: rtl/rr_path_rewriter.sv
module rr_path_rewriter
  import rr_pkg::*;
#(
  parameter int HOPS   = 16,
  parameter int VCS    = 2,
  parameter int LEN_W  = $clog2(HOPS + 1),
  parameter int PATH_W = HOPS * HOP_W,
  parameter int VC_W   = (VCS > 1) ? $clog2(VCS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VC_W-1:0]   req_vc_i,
  input  logic [2:0]        req_inport_i,
  input  logic [2:0]        req_blk_i,
  input  logic [PATH_W-1:0] req_path_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [PORTS-1:0]  out_free_i,
  output logic              busy_o,
  output logic              hdr_valid_o,
  output logic [VC_W-1:0]   hdr_vc_o,
  output logic [2:0]        hdr_port_o,
  output logic [PATH_W-1:0] hdr_path_o,
  output logic [LEN_W-1:0]  hdr_len_o,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_inport_o,
  output logic [VC_W-1:0]   cmd_vc_o,
  output logic              cmd_drop_o
);
  // single header buffer shared by all virtual channels
  logic              buf_v;
  logic [VC_W-1:0]   buf_vc;
  logic [2:0]        buf_inp, buf_blk;
  logic [PATH_W-1:0] buf_path;
  logic [LEN_W-1:0]  buf_len;

  logic       side_ok, drop, ready, accept, issue;
  logic [2:0] side;

  assign accept = req_valid_i && !buf_v;
  assign issue  = buf_v && (ready || drop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_v    <= 1'b0;
      buf_vc   <= '0;
      buf_inp  <= '0;
      buf_blk  <= '0;
      buf_path <= '0;
      buf_len  <= '0;
    end else if (accept) begin
      buf_v    <= 1'b1;
      buf_vc   <= req_vc_i;
      buf_inp  <= req_inport_i;
      buf_blk  <= req_blk_i;
      buf_path <= req_path_i;
      buf_len  <= req_len_i;
    end else if (issue) begin
      buf_v    <= 1'b0;
    end
  end

  rr_side_pick u_side (
    .blk_i     (buf_blk),
    .in_port_i (buf_inp),
    .free_i    (out_free_i),
    .ok_o      (side_ok),
    .side_o    (side)
  );

  rr_path_edit #(.HOPS(HOPS), .LEN_W(LEN_W), .PATH_W(PATH_W)) u_edit (
    .path_i    (buf_path),
    .len_i     (buf_len),
    .blk_i     (buf_blk),
    .in_port_i (buf_inp),
    .free_i    (out_free_i),
    .side_ok_i (side_ok),
    .side_i    (side),
    .drop_o    (drop),
    .ready_o   (ready),
    .port_o    (hdr_port_o),
    .path_o    (hdr_path_o),
    .len_o     (hdr_len_o)
  );

  assign busy_o       = buf_v;
  assign hdr_valid_o  = buf_v && ready;
  assign hdr_vc_o     = buf_vc;
  assign cmd_valid_o  = issue;
  assign cmd_inport_o = buf_inp;
  assign cmd_vc_o     = buf_vc;
  assign cmd_drop_o   = buf_v && drop;

  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o |=> busy_o);  // R2
  AST_HOLD_UNTIL_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !cmd_valid_o |=> busy_o && $stable(cmd_inport_o));  // R9
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !busy_o);  // R2
  AST_PORT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> out_free_i[hdr_port_o] && (hdr_port_o != cmd_inport_o));  // R9
  AST_DROP_NO_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_drop_o |-> cmd_valid_o && !hdr_valid_o);  // R8
  AST_HDR_WITH_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> cmd_valid_o && (hdr_vc_o == cmd_vc_o));  // R10
  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> (hdr_len_o <= LEN_W'(HOPS)) && (hdr_len_o >= buf_len));  // R4
  AST_WEST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o && is_vert(buf_blk) && (hdr_len_o == buf_len + LEN_W'(2)) &&
    out_free_i[DIR_W] && (buf_inp != DIR_W) |-> hdr_port_o == DIR_W);  // R7
endmodule

// File: tb/sim_rr_path_rewriter.sv
module sim_rr_path_rewriter;
  localparam int HOPS = 16;
  localparam int PW   = HOPS * 3;
  localparam int LW   = 5;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_vc = 1'b0;
  logic [2:0]    req_inp = '0, req_blk = '0;
  logic [PW-1:0] req_path = '0;
  logic [LW-1:0] req_len = '0;
  logic [4:0]    free = '0;
  logic          busy, hdr_valid, hdr_vc, cmd_valid, cmd_vc, cmd_drop;
  logic [2:0]    hdr_port, cmd_inp;
  logic [PW-1:0] hdr_path;
  logic [LW-1:0] hdr_len;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rr_path_rewriter #(.HOPS(HOPS), .VCS(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vc_i(req_vc),
    .req_inport_i(req_inp), .req_blk_i(req_blk), .req_path_i(req_path),
    .req_len_i(req_len), .out_free_i(free), .busy_o(busy),
    .hdr_valid_o(hdr_valid), .hdr_vc_o(hdr_vc), .hdr_port_o(hdr_port),
    .hdr_path_o(hdr_path), .hdr_len_o(hdr_len), .cmd_valid_o(cmd_valid),
    .cmd_inport_o(cmd_inp), .cmd_vc_o(cmd_vc), .cmd_drop_o(cmd_drop));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit vert(input int d); return d == 1 || d == 3; endfunction
  function automatic bit mesh(input int d); return d >= 1 && d <= 4; endfunction
  function automatic int back(input int d); return mesh(d) ? ((d + 1) % 4) + 1 : 0; endfunction

  // expected result computed from the requirements
  function automatic void model(input logic [PW-1:0] p, input int len, input int d,
      input int inp, input logic [4:0] fr, output bit drop, output bit stall,
      output int port, output logic [PW-1:0] np, output int nlen);
    int h1, h2;
    h1 = int'(p[3 +: 3]);
    h2 = int'(p[6 +: 3]);
    drop = 0; stall = 0; port = 0; np = p; nlen = len;
    if (len <= 1 || !mesh(d)) begin drop = 1; return; end
    if (mesh(h1) && vert(h1) != vert(d)) begin          // R6
      port = h1; np[2:0] = 3'(h1); np[5:3] = 3'(d);
    end else if (h1 == d && len >= 3 && mesh(h2) && vert(h2) != vert(d)) begin  // R5
      port = h2; np[2:0] = 3'(h2); np[5:3] = 3'(d); np[8:6] = 3'(d);
    end else if (h1 == d) begin                          // R4
      int c0, c1;
      if (len + 2 > HOPS) begin drop = 1; return; end
      c0 = vert(d) ? 4 : 1;
      c1 = vert(d) ? 2 : 3;
      if (fr[c0] && c0 != inp) port = c0;
      else if (fr[c1] && c1 != inp) port = c1;
      else begin stall = 1; return; end
      np = p << 6;
      np[2:0] = 3'(port); np[5:3] = 3'(d); np[8:6] = 3'(d); np[11:9] = 3'(back(port));
      nlen = len + 2;
      return;
    end else begin drop = 1; return; end
    if (!fr[port] || port == inp) stall = 1;
  endfunction

  task automatic compare(input logic [PW-1:0] p, input int len, input int d,
      input int inp, input bit vc, input string tag);
    bit drop, stall; int port, nlen; logic [PW-1:0] np;
    model(p, len, d, inp, free, drop, stall, port, np, nlen);
    chk(cmd_valid == 1'b1, {tag, " R10 cmd_valid"}, cmd_valid, 1);
    chk(cmd_drop == drop, {tag, " R8 cmd_drop"}, cmd_drop, drop);
    chk(hdr_valid == !drop, {tag, " R10 hdr_valid"}, hdr_valid, !drop);
    chk(cmd_inp == 3'(inp) && cmd_vc == vc, {tag, " R10 cmd fields"}, {cmd_inp, cmd_vc}, {3'(inp), vc});
    if (!drop) begin
      logic [PW-1:0] m = '0;
      for (int k = 0; k < nlen; k++) m[k*3 +: 3] = 3'b111;
      chk(hdr_port == 3'(port), {tag, " R7 port"}, hdr_port, port);
      chk(hdr_len == LW'(nlen), {tag, " R3 len"}, hdr_len, nlen);
      chk((hdr_path & m) == (np & m), {tag, " R3 path"}, hdr_path & m, np & m);
      chk(hdr_vc == vc, {tag, " R10 hdr_vc"}, hdr_vc, vc);
    end
  endtask

  task automatic txn(input logic [PW-1:0] p, input int len, input int d,
      input int inp, input bit vc, input logic [4:0] fr, input string tag);
    bit drop, stall; int port, nlen; logic [PW-1:0] np;
    model(p, len, d, inp, 5'b11111, drop, stall, port, np, nlen);
    if (stall) return;  // never legal: skipped
    @(negedge clk);
    free = fr; req_valid = 1; req_vc = vc; req_inp = 3'(inp); req_blk = 3'(d);
    req_path = p; req_len = LW'(len);
    @(negedge clk);
    req_valid = 0;
    model(p, len, d, inp, free, drop, stall, port, np, nlen);
    if (stall) begin
      chk(busy && !hdr_valid && !cmd_valid, {tag, " R9 wait"}, {busy, hdr_valid, cmd_valid}, 3'b100);
      req_valid = 1; req_path = '1; req_len = LW'(1); req_inp = 3'(back(inp)); req_vc = !vc;
      @(negedge clk);
      req_valid = 0;
      chk(busy && !cmd_valid, {tag, " R2 refused while busy"}, {busy, cmd_valid}, 2'b10);
      free = 5'b11111;
      #1;
    end
    compare(p, len, d, inp, vc, tag);
    @(negedge clk);
    chk(!busy && !cmd_valid, {tag, " R2 release"}, {busy, cmd_valid}, 2'b00);
  endtask

  function automatic logic [PW-1:0] mk(input int shape, input int d, input int t, output int len);
    logic [PW-1:0] p = '0;
    int seq [16];
    for (int k = 0; k < 16; k++) seq[k] = d;
    case (shape)
      0: len = 1;
      1: len = 2;
      2: begin len = 5; seq[3] = t; seq[4] = t; end
      3: begin len = 3; seq[1] = t; seq[2] = t; end
      4: begin len = 4; seq[2] = t; seq[3] = t; end
      5: len = 14;
      default: len = 15;
    endcase
    for (int k = 0; k < len; k++) p[k*3 +: 3] = 3'(seq[k]);
    return p;
  endfunction

  initial begin
    #2;
    chk(!busy && !hdr_valid && !cmd_valid && !cmd_drop, "R1 reset", {busy, hdr_valid, cmd_valid, cmd_drop}, 0);
    #30 rst_n = 1;
    @(negedge clk);
    chk(!busy && !cmd_valid, "R1 after reset", {busy, cmd_valid}, 0);
    for (int d = 1; d <= 4; d++)
      for (int ts = 0; ts < 2; ts++)
        for (int sh = 0; sh < 7; sh++)
          for (int inp = 0; inp < 5; inp++)
            for (int fm = 0; fm < 32; fm++) begin
              int len, t;
              logic [PW-1:0] p;
              t = vert(d) ? (ts ? 4 : 2) : (ts ? 3 : 1);
              p = mk(sh, d, t, len);
              txn(p, len, d, inp, 1'((fm + sh) & 1), 5'(fm), $sformatf("d%0d s%0d i%0d f%0d", d, sh, inp, fm));
            end
    // R8: blocked local port, and hop 1 pointing backwards
    txn({42'd0, 3'd1, 3'd0}, 2, 0, 2, 0, 5'b11111, "R8 blocked local");
    txn({42'd0, 3'd3, 3'd1}, 2, 1, 2, 1, 5'b11111, "R8 reversed hop");
    txn({42'd0, 3'd0, 3'd2}, 2, 2, 1, 0, 5'b11111, "R8 local hop1");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule